// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through data cache and the next level of memory. It takes CPU stores into a few small entries. Each entry covers one aligned block of several 64-bit words. A store completes in the cycle it is offered whenever the buffer can take it. A store that falls in a block already held by an unlocked entry goes into that entry: it sets that word's valid bit and takes no new slot. Otherwise the store takes a free slot. Entries leave for memory one at a time, oldest first, as a single write that carries the block address, a word-valid mask and every data word of the block.

The cache controller can also present a read-miss address to a combinational lookup port. If no valid entry covers that block, the read can go to memory ahead of the queued writes. If an entry does cover it, the port raises a conflict flag. When the requested word is held, the port also returns the newest copy of that word, so the caller can forward it or wait.

A drain starts in one of three cases: the oldest entry is complete, a newer entry exists behind it, or no store has been accepted for a set number of cycles. Once a drain starts, its entry is locked. Stores to that block then open a fresh entry.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_valid` is 0 and a lookup reports neither conflict nor hit.
- R2: When there is no unlocked match and at least one entry is free, a store is accepted in the same cycle with `st_ready` high. It does not wait for memory.
- R3: Stores whose addresses share the block bits (`addr[ADDR_W-1:5]` at default widths) and that find an unlocked matching entry all merge into that one entry. Four stores to the four words of one block drain as a single memory write with mask `4'b1111`.
- R4: When every entry is valid, no unlocked entry matches the store, and no drain completes in that cycle, `st_ready` is 0 and the store is not taken.
- R5: Drains leave in allocation order. `mem_addr` is the block base address, with its low 5 bits at zero. Mask bit i marks word i, where i is `addr[4:3]`. Word i sits at `mem_data[64*i +: 64]`, and words that were never written read as zero.
- R6: A drain starts when the oldest entry has all word bits set, or when more than one entry is valid, or after `IDLE_LIMIT` cycles with no accepted store. Its address, mask and data then hold steady until `mem_ready`. `mem_valid` drops in the cycle after the handshake.
- R7: Once its drain has started, the oldest entry is locked. A store to its block takes a new entry instead of merging, and the store's data appears only in a later drain.
- R8: A lookup raises `rd_conflict` when its block matches any valid entry. It raises `rd_hit` when the addressed word is valid in such an entry, and `rd_data` then returns the copy from the newest such entry.
- R9: When the buffer is full and a drain completes in that same cycle, a non-matching store is accepted into the freed entry.
- R10: A store to a word that is already valid in an unlocked entry overwrites that word's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | CPU store request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| st_ready | output | 1 | Store accepted this cycle; low means stall |
| rd_addr | input | ADDR_W | Read-miss byte address to check |
| rd_conflict | output | 1 | Some valid entry holds the read's block |
| rd_hit | output | 1 | The addressed word is held |
| rd_data | output | DATA_W | Newest held copy of the word |
| mem_valid | output | 1 | Drain write offered to memory |
| mem_ready | input | 1 | Memory takes the drain write |
| mem_addr | output | ADDR_W | Block base address of the drain |
| mem_mask | output | WORDS | Word-valid mask of the drain |
| mem_data | output | WORDS*DATA_W | All data words of the drained block |

## Verification
Some properties are checked by assertions on every cycle. A stall only happens with every entry occupied, and the occupancy never exceeds the depth. At most one unlocked entry matches a store. An offered drain stays stable with a nonzero mask until it is taken. A word hit always comes with a block conflict. Other behaviours only the directed scenarios can show: merging into a single entry, the overwrite of a repeated word, oldest-first order, the lock forcing a fresh entry, the newest-copy choice on lookup, the idle-timeout drain, and the same-cycle reuse of a freed slot.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned TAG_W   = 27
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]              key,
   output logic [ENTRIES-1:0]            hit
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit[g] = valid[g] && (tags[g] == key);
   end
endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned WORDS   = 4,
   parameter int unsigned DATA_W  = 64,
   localparam int unsigned IW     = $clog2(ENTRIES),
   localparam int unsigned WW     = $clog2(WORDS)
) (
   input  logic [ENTRIES-1:0]                   blk_hit,
   input  logic [ENTRIES-1:0][WORDS-1:0]        masks,
   input  logic [ENTRIES-1:0][WORDS*DATA_W-1:0] datas,
   input  logic [IW-1:0]                        oldest,
   input  logic [WW-1:0]                        widx,
   output logic                                 conflict,
   output logic                                 hit,
   output logic [DATA_W-1:0]                    data
);
   always_comb begin
      conflict = 1'b0;
      hit      = 1'b0;
      data     = '0;
      // walk oldest to newest so the newest copy wins
      for (int k = 0; k < ENTRIES; k++) begin
         logic [IW-1:0] idx;
         idx = oldest + IW'(k);
         if (blk_hit[idx]) begin
            conflict = 1'b1;
            if (masks[idx][widx]) begin
               hit  = 1'b1;
               data = datas[idx][widx*DATA_W +: DATA_W];
            end
         end
      end
   end
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain #(
   parameter int unsigned IDLE_LIMIT = 8,
   localparam int unsigned CW        = $clog2(IDLE_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nonempty,
   input  logic multi,
   input  logic head_full,
   input  logic st_accept,
   input  logic mem_ready,
   output logic draining
);
   logic [CW-1:0] idle_q;
   logic          start, done;

   assign done  = draining && mem_ready;
   assign start = !draining && nonempty &&
                  (head_full || multi || (idle_q >= CW'(IDLE_LIMIT)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draining <= 1'b0;
         idle_q   <= '0;
      end else begin
         if (done)       draining <= 1'b0;
         else if (start) draining <= 1'b1;
         if (st_accept || draining || !nonempty) idle_q <= '0;
         else if (idle_q < CW'(IDLE_LIMIT))      idle_q <= idle_q + 1'b1;
      end
   end

   a_r6_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !draining);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned WORDS      = 4,
   parameter int unsigned ENTRIES    = 4,
   parameter int unsigned IDLE_LIMIT = 8,
   localparam int unsigned BYTE_OFS  = $clog2(DATA_W / 8),
   localparam int unsigned WW        = $clog2(WORDS),
   localparam int unsigned BLK_LSB   = BYTE_OFS + WW,
   localparam int unsigned TAG_W     = ADDR_W - BLK_LSB,
   localparam int unsigned IW        = $clog2(ENTRIES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [DATA_W-1:0]       st_data,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic                    rd_conflict,
   output logic                    rd_hit,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [WORDS-1:0]        mem_mask,
   output logic [WORDS*DATA_W-1:0] mem_data
);
   import wbuf_pkg::*;

   initial begin
      a_cfg_words: assert (is_pow2(WORDS) && WORDS >= 2);
      a_cfg_entries: assert (is_pow2(ENTRIES) && ENTRIES >= 2);
      a_cfg_data: assert (is_pow2(DATA_W) && DATA_W >= 8);
      a_cfg_addr: assert (ADDR_W > BLK_LSB);
   end

   logic [ENTRIES-1:0]                   v_q;
   logic [ENTRIES-1:0][TAG_W-1:0]        tag_q;
   logic [ENTRIES-1:0][WORDS-1:0]        msk_q;
   logic [ENTRIES-1:0][WORDS*DATA_W-1:0] dat_q;
   logic [IW-1:0]                        head_q, tail_q;
   logic [IW:0]                          cnt_q;

   logic [ENTRIES-1:0] st_match, rd_match, lock_v, st_hit;
   logic [IW-1:0]      st_idx;
   logic               merge, accept, alloc, done, draining;
   logic [TAG_W-1:0]   st_tag, rd_tag;
   logic [WW-1:0]      st_w, rd_w;

   assign st_tag = st_addr[ADDR_W-1:BLK_LSB];
   assign st_w   = st_addr[BLK_LSB-1:BYTE_OFS];
   assign rd_tag = rd_addr[ADDR_W-1:BLK_LSB];
   assign rd_w   = rd_addr[BLK_LSB-1:BYTE_OFS];

   wbuf_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_st_match (
      .valid(v_q), .tags(tag_q), .key(st_tag), .hit(st_match));

   wbuf_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rd_match (
      .valid(v_q), .tags(tag_q), .key(rd_tag), .hit(rd_match));

   wbuf_lookup #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W)) u_lookup (
      .blk_hit(rd_match), .masks(msk_q), .datas(dat_q), .oldest(head_q),
      .widx(rd_w), .conflict(rd_conflict), .hit(rd_hit), .data(rd_data));

   wbuf_drain #(.IDLE_LIMIT(IDLE_LIMIT)) u_drain (
      .clk(clk), .rst_n(rst_n),
      .nonempty(cnt_q != '0), .multi(cnt_q > (IW+1)'(1)),
      .head_full(&msk_q[head_q]), .st_accept(accept),
      .mem_ready(mem_ready), .draining(draining));

   always_comb begin
      lock_v = '0;
      if (draining) lock_v[head_q] = 1'b1;
   end

   assign st_hit = st_match & ~lock_v;
   assign merge  = |st_hit;

   always_comb begin
      st_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (st_hit[i]) st_idx = IW'(i);
   end

   assign mem_valid = draining;
   assign done      = draining && mem_ready;
   assign st_ready  = merge || (cnt_q < (IW+1)'(ENTRIES)) || done;
   assign accept    = st_valid && st_ready;
   assign alloc     = accept && !merge;
   assign mem_addr  = {tag_q[head_q], {BLK_LSB{1'b0}}};
   assign mem_mask  = msk_q[head_q];
   assign mem_data  = dat_q[head_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= '0;
         tag_q  <= '0;
         msk_q  <= '0;
         dat_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (done) begin
            v_q[head_q]   <= 1'b0;
            msk_q[head_q] <= '0;
            head_q        <= head_q + 1'b1;
         end
         if (accept && merge) begin
            msk_q[st_idx][st_w]                     <= 1'b1;
            dat_q[st_idx][st_w*DATA_W +: DATA_W]    <= st_data;
         end else if (alloc) begin
            v_q[tail_q]                             <= 1'b1;
            tag_q[tail_q]                           <= st_tag;
            msk_q[tail_q]                           <= '0;
            msk_q[tail_q][st_w]                     <= 1'b1;
            dat_q[tail_q]                           <= '0;
            dat_q[tail_q][st_w*DATA_W +: DATA_W]    <= st_data;
            tail_q                                  <= tail_q + 1'b1;
         end
         cnt_q <= cnt_q + (IW+1)'(alloc) - (IW+1)'(done);
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (IW+1)'(ENTRIES));
   a_r4_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |-> (v_q == '1));
   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_hit));
   a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_mask != '0));
   a_r6_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                     $stable(mem_mask) && $stable(mem_data)));
   a_r8_hit_implies_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> rd_conflict);
endmodule

// File: tb/tb_merge_wbuf.sv
`timescale 1ns/1ps
module tb_merge_wbuf;
   localparam int unsigned AW = 32, DW = 64, NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_ready;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_conflict, rd_hit;
   logic [DW-1:0] rd_data;
   logic          mem_valid;
   logic          mem_ready = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [NW-1:0] mem_mask;
   logic [NW*DW-1:0] mem_data;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   merge_wbuf dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_ready(st_ready), .rd_addr(rd_addr),
      .rd_conflict(rd_conflict), .rd_hit(rd_hit), .rd_data(rd_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_mask(mem_mask), .mem_data(mem_data));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int n);
      return 64'hA5A5_0000_0000_0000 | 64'(n);
   endfunction

   task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d;
      #1 chk(st_ready, "R2 store accepted", 64'(st_ready), 1);
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic wait_mv();
      for (int i = 0; i < 60 && !mem_valid; i++) @(negedge clk);
      #1;
   endtask

   task automatic release_drain();
      @(negedge clk);
      mem_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_ready = 1'b0;
      #1 chk(!mem_valid, "R6 valid drops after handshake", 64'(mem_valid), 0);
   endtask

   task automatic drain_one(input logic [AW-1:0] a, input logic [NW-1:0] m,
                            input int w, input logic [63:0] d, input string req);
      wait_mv();
      chk(mem_valid, req, 64'(mem_valid), 1);
      chk(mem_addr == a, req, 64'(mem_addr), 64'(a));
      chk(mem_mask == m, req, 64'(mem_mask), 64'(m));
      chk(mem_data[w*DW +: DW] == d, req, mem_data[w*DW +: DW], d);
      release_drain();
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk(st_ready, "R1 ready at reset", 64'(st_ready), 1);
      chk(!mem_valid, "R1 no drain at reset", 64'(mem_valid), 0);
      rd_addr = 32'h1000; #1;
      chk(!rd_conflict && !rd_hit, "R1 empty lookup", 64'({rd_conflict, rd_hit}), 0);
   endtask

   // merge, overwrite, lookup, lock, newest copy, idle drain
   task automatic t_merge_lock();
      store(32'h1000, pat(0));
      store(32'h1008, pat(1));
      store(32'h1010, pat(2));
      store(32'h1000, pat(9));  // R10 overwrite word 0
      rd_addr = 32'h1008; #1;
      chk(rd_conflict && rd_hit, "R8 lookup hit", 64'({rd_conflict, rd_hit}), 3);
      chk(rd_data == pat(1), "R8 lookup data", rd_data, pat(1));
      rd_addr = 32'h1018; #1;
      chk(rd_conflict && !rd_hit, "R8 conflict no word", 64'({rd_conflict, rd_hit}), 2);
      rd_addr = 32'h5000; #1;
      chk(!rd_conflict, "R8 no conflict other block", 64'(rd_conflict), 0);
      store(32'h1018, pat(3));
      wait_mv();
      chk(mem_addr == 32'h1000, "R3 single entry addr", 64'(mem_addr), 64'h1000);
      chk(mem_mask == 4'b1111, "R3 full mask", 64'(mem_mask), 64'hF);
      chk(mem_data[0 +: DW] == pat(9), "R10 overwritten word", mem_data[0 +: DW], pat(9));
      chk(mem_data[3*DW +: DW] == pat(3), "R5 word 3 position", mem_data[3*DW +: DW], pat(3));
      for (int i = 0; i < 3; i++) @(negedge clk);
      #1 chk(mem_valid && mem_addr == 32'h1000, "R6 held until ready", 64'(mem_addr), 64'h1000);
      store(32'h1008, pat(7));   // R7 locked head: new entry
      rd_addr = 32'h1008; #1;
      chk(rd_hit && rd_data == pat(7), "R8 newest copy", rd_data, pat(7));
      chk(mem_data[DW +: DW] == pat(1), "R7 locked entry unchanged", mem_data[DW +: DW], pat(1));
      release_drain();
      drain_one(32'h1000, 4'b0010, 1, pat(7), "R7 store in new entry, R6 idle drain");
   endtask

   // full buffer stall, same-cycle reuse, oldest-first order
   task automatic t_full_order();
      store(32'h2010, pat(20));
      store(32'h2030, pat(21));
      store(32'h2050, pat(22));
      store(32'h2070, pat(23));
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h2090; st_data = pat(24);
      #1 chk(!st_ready, "R4 stall when full", 64'(st_ready), 0);
      @(posedge clk);
      @(negedge clk); #1;
      chk(!st_ready, "R4 still stalled", 64'(st_ready), 0);
      chk(mem_valid && mem_addr == 32'h2000, "R5 oldest first", 64'(mem_addr), 64'h2000);
      mem_ready = 1'b1; #1;
      chk(st_ready, "R9 freed entry reused", 64'(st_ready), 1);
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0; mem_ready = 1'b0;
      drain_one(32'h2020, 4'b0100, 2, pat(21), "R5 order C");
      drain_one(32'h2040, 4'b0100, 2, pat(22), "R5 order D");
      drain_one(32'h2060, 4'b0100, 2, pat(23), "R5 order E");
      drain_one(32'h2080, 4'b0100, 2, pat(24), "R9 stalled store drained");
      rd_addr = 32'h2088; #1;
      chk(!rd_conflict, "R8 empty after drains", 64'(rd_conflict), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_merge_lock();
      t_full_order();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule